// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block produces one pulse-width-modulated output from a free-running input clock. The clock first passes through a power-of-two prescaler, and the resulting ticks drive a period counter. Each period lasts a programmed number of ticks. The output is high for a programmed number of ticks at the start of each period and low for the rest. Software controls the block through two 32-bit registers on a simple read/write bus with address, write data, write strobe and combinational read data.

The divider exponent is stored in two control fields that are joined together. Setting a hold bit lets software change the period, the high time and the divider together. While the hold bit is set, those writes are only staged. Clearing the bit commits them all at once, and a running counter starts using them at its next period boundary. Zero period or zero high time is a prohibited setting. An enable request made with either count field at zero is refused. A running channel whose committed values become zero is forced low and held in reset.

The sequencer is a three-state machine. `ST_HOLD` keeps the output low and holds the prescaler and counter at zero. `ST_HIGH` and `ST_LOW` are the two running phases. The transitions are:
- `ST_HOLD` to `ST_HIGH` on *start*, when the channel becomes active.
- `ST_HIGH` to `ST_LOW` on *phase end*, at the tick where the position reaches the high time.
- `ST_LOW` or `ST_HIGH` to `ST_HIGH` on *wrap*, at the last tick of a period, which also reloads the working values.
- Any running state to `ST_HOLD` on *stop*, when the channel is disabled or a zero setting becomes active.

Top module: `pwm_prescale_timer`

## Requirements
- R1: After reset, both registers read zero and `pwm_o` is low.
- R2: The control word at byte address 0x0 has these fields, and each reads back its last written value:
  - enable at bit 0
  - a free general-purpose flag at bit 4
  - the hold bit at bit 11
  - the divider exponent LSB at bit 15
  - the upper four exponent bits at 19:16

  The count word at 0x4 holds the period at 25:16 and the high time at 9:0. All other bits read zero.
- R3: Reads from any other address return zero, and writes to any other address change neither register.
- R4: With exponent d = {bits 19:16, bit 15}, period value P and high value H (H < P), the output repeats with a period of P·2^d clocks and stays high for H·2^d clocks of each period.
- R5: When H is greater than or equal to P, the output stays high continuously while the channel runs.
- R6: An exponent above the parameter EXP_MAX is treated as EXP_MAX.
- R7: A control write that sets enable while the stored period or high field is zero stores enable as 0.
- R8: If a running channel's committed period or high value becomes zero, the output goes low and stays low while the enable bit still reads 1. Restoring non-zero values restarts the channel from the beginning of a period.
- R9: With enable at 0 the output is low. Enabling the channel starts a new period from position zero, and the first high pulse has the full length H·2^d.
- R10: While the hold bit reads 1, writes to the period, high time and divider do not change the output waveform. When the bit is cleared, all three take effect together from the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with EXP_MAX = 6 and ADDR_W = 4, and keeps the 10-bit count fields. The small exponent limit makes the saturation rule reachable: the largest encodable exponent, 31, must give the same waveform as an exponent of 6. At 2^6 that waveform spans only a few hundred clocks, where the default limit would need millions. With four address bits, the unmapped words at 0x8 and 0xC can also be read and written, so the address decode is tested against real holes in the map.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    // register byte offsets
    localparam int OFS_CTRL = 0;
    localparam int OFS_CNT  = 4;

    // control field positions
    localparam int BIT_RUN  = 0;
    localparam int BIT_FLAG = 4;
    localparam int BIT_HOLD = 11;
    localparam int BIT_DLSB = 15;
    localparam int DHI_LSB  = 16;
    localparam int DHI_W    = 4;

    // count field positions
    localparam int PER_LSB  = 16;
    localparam int HI_LSB   = 0;

    // raw exponent width: one LSB plus the upper field
    localparam int RAW_EXP_W = DHI_W + 1;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pwm_state_e;

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int CNT_W   = 10,
    parameter int EXP_MAX = 24
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [31:0]                        bus_wdata,
    input  logic                               bus_we,
    output logic [31:0]                        bus_rdata,
    output logic                               run_o,
    output logic [CNT_W-1:0]                   per_c_o,
    output logic [CNT_W-1:0]                   hi_c_o,
    output logic [$clog2(EXP_MAX+1)-1:0]       exp_c_o
);
    localparam int EXP_W = $clog2(EXP_MAX + 1);

    logic             run_q, flag_q, hold_q, dlsb_q;
    logic [DHI_W-1:0] dhi_q;
    logic [CNT_W-1:0] per_q, hi_q;

    logic             run_d, flag_d, hold_d, dlsb_d;
    logic [DHI_W-1:0] dhi_d;
    logic [CNT_W-1:0] per_d, hi_d;

    logic [CNT_W-1:0] per_c, hi_c;
    logic [EXP_W-1:0] exp_c, exp_sat;
    logic [RAW_EXP_W-1:0] raw_exp;

    logic sel_ctrl, sel_cnt;
    logic unused_wdata;

    assign sel_ctrl     = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_cnt      = (bus_addr == ADDR_W'(OFS_CNT));
    assign unused_wdata = ^bus_wdata;

    // next-state of the visible fields
    always_comb begin
        run_d  = run_q;
        flag_d = flag_q;
        hold_d = hold_q;
        dlsb_d = dlsb_q;
        dhi_d  = dhi_q;
        per_d  = per_q;
        hi_d   = hi_q;
        if (bus_we && sel_cnt) begin
            per_d = bus_wdata[PER_LSB +: CNT_W];
            hi_d  = bus_wdata[HI_LSB +: CNT_W];
        end
        if (bus_we && sel_ctrl) begin
            // enable refused while either stored count field is zero
            run_d  = bus_wdata[BIT_RUN] && (per_q != '0) && (hi_q != '0);
            flag_d = bus_wdata[BIT_FLAG];
            hold_d = bus_wdata[BIT_HOLD];
            dlsb_d = bus_wdata[BIT_DLSB];
            dhi_d  = bus_wdata[DHI_LSB +: DHI_W];
        end
    end

    assign raw_exp = {dhi_d, dlsb_d};
    assign exp_sat = (int'(raw_exp) > EXP_MAX) ? EXP_W'(EXP_MAX) : EXP_W'(raw_exp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            flag_q <= 1'b0;
            hold_q <= 1'b0;
            dlsb_q <= 1'b0;
            dhi_q  <= '0;
            per_q  <= '0;
            hi_q   <= '0;
        end else begin
            run_q  <= run_d;
            flag_q <= flag_d;
            hold_q <= hold_d;
            dlsb_q <= dlsb_d;
            dhi_q  <= dhi_d;
            per_q  <= per_d;
            hi_q   <= hi_d;
        end
    end

    // committed copies follow the staged fields whenever hold ends up clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_c <= '0;
            hi_c  <= '0;
            exp_c <= '0;
        end else if (!hold_d) begin
            per_c <= per_d;
            hi_c  <= hi_d;
            exp_c <= exp_sat;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[BIT_RUN]              = run_q;
            bus_rdata[BIT_FLAG]             = flag_q;
            bus_rdata[BIT_HOLD]             = hold_q;
            bus_rdata[BIT_DLSB]             = dlsb_q;
            bus_rdata[DHI_LSB +: DHI_W]     = dhi_q;
        end else if (sel_cnt) begin
            bus_rdata[PER_LSB +: CNT_W]     = per_q;
            bus_rdata[HI_LSB +: CNT_W]      = hi_q;
        end
    end

    assign run_o   = run_q;
    assign per_c_o = per_c;
    assign hi_c_o  = hi_c;
    assign exp_c_o = exp_c;

    AST_ENABLE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel_ctrl && ((per_q == '0) || (hi_q == '0))) |=> !run_q); // R7

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !(bus_we && sel_ctrl && !bus_wdata[BIT_HOLD]))
        |=> ($stable(per_c) && $stable(hi_c) && $stable(exp_c))); // R10

endmodule

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale #(
    parameter int EXP_MAX = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic [$clog2(EXP_MAX+1)-1:0] exp_i,
    output logic                         tick_o
);
    localparam int EXP_W = $clog2(EXP_MAX + 1);
    localparam int PRE_W = (EXP_MAX < 1) ? 1 : EXP_MAX;

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] mask;

    // terminal count is 2^exp - 1: low exp bits set
    for (genvar gi = 0; gi < PRE_W; gi++) begin : g_mask
        assign mask[gi] = (gi < int'(exp_i));
    end

    assign tick_o = !clr_i && (cnt_q == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRE_W'(1);
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (exp_i != '0) && !clr_i) |=> !tick_o); // R4

endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int EXP_MAX = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run_i,
    input  logic [CNT_W-1:0]             per_i,
    input  logic [CNT_W-1:0]             hi_i,
    input  logic [$clog2(EXP_MAX+1)-1:0] exp_i,
    output logic                         pwm_o
);
    localparam int EXP_W = $clog2(EXP_MAX + 1);

    pwm_state_e       state_q, state_d;
    logic [CNT_W-1:0] pos_q, pos_d;
    logic [CNT_W-1:0] per_w, hi_w;
    logic [EXP_W-1:0] exp_w;
    logic             active, load, tick, pre_clr;

    assign active  = run_i && (per_i != '0) && (hi_i != '0);
    assign pre_clr = !active || (state_q == ST_HOLD);

    pwm_tmr_prescale #(
        .EXP_MAX (EXP_MAX)
    ) i_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pre_clr),
        .exp_i  (exp_w),
        .tick_o (tick)
    );

    // next state and position
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        load    = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                load  = 1'b1;
                pos_d = '0;
                if (active) begin
                    state_d = ST_HIGH;          // start
                end
            end
            ST_HIGH, ST_LOW: begin
                if (!active) begin
                    state_d = ST_HOLD;          // stop
                    pos_d   = '0;
                end else if (tick) begin
                    if (pos_q >= per_w - CNT_W'(1)) begin
                        pos_d   = '0;           // wrap
                        load    = 1'b1;
                        state_d = ST_HIGH;
                    end else begin
                        pos_d   = pos_q + CNT_W'(1);
                        state_d = ((pos_q + CNT_W'(1)) < hi_w) ? ST_HIGH : ST_LOW;
                    end
                end
            end
            default: begin
                state_d = ST_HOLD;
                pos_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // working copies, reloaded in hold and at each wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_w <= '0;
            hi_w  <= '0;
            exp_w <= '0;
        end else if (load) begin
            per_w <= per_i;
            hi_w  <= hi_i;
            exp_w <= exp_i;
        end
    end

    // outputs
    always_comb begin
        pwm_o = (state_q == ST_HIGH);
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pwm_o); // R8

    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HOLD) && active) |=> (pwm_o && (pos_q == '0))); // R9

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HOLD) |-> (pos_q < per_w)); // R4

endmodule

// File: rtl/pwm_prescale_timer.sv
module pwm_prescale_timer #(
    parameter int ADDR_W  = 4,
    parameter int CNT_W   = 10,
    parameter int EXP_MAX = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              pwm_o
);
    localparam int EXP_W = $clog2(EXP_MAX + 1);

    logic             run;
    logic [CNT_W-1:0] per_c, hi_c;
    logic [EXP_W-1:0] exp_c;

    pwm_tmr_regs #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .EXP_MAX (EXP_MAX)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .run_o     (run),
        .per_c_o   (per_c),
        .hi_c_o    (hi_c),
        .exp_c_o   (exp_c)
    );

    pwm_tmr_core #(
        .CNT_W   (CNT_W),
        .EXP_MAX (EXP_MAX)
    ) i_core (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .per_i (per_c),
        .hi_i  (hi_c),
        .exp_i (exp_c),
        .pwm_o (pwm_o)
    );

endmodule

// File: tb/test_pwm_prescale_timer.sv
`timescale 1ns/1ps
module test_pwm_prescale_timer;

    localparam int ADDR_W  = 4;
    localparam int EXP_MAX = 6;
    localparam int LIMIT   = 5000;

    typedef struct packed {
        logic        dl;
        logic [3:0]  dh;
        logic [9:0]  per;
        logic [9:0]  hi;
        logic [31:0] exp_hi;
        logic [31:0] exp_per;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'd0,  10'd4,    10'd1, 32'd1,  32'd4},
        '{1'b1, 4'd0,  10'd5,    10'd2, 32'd4,  32'd10},
        '{1'b0, 4'd1,  10'd3,    10'd1, 32'd4,  32'd12},
        '{1'b1, 4'd1,  10'd6,    10'd5, 32'd40, 32'd48},
        '{1'b0, 4'd0,  10'd1023, 10'd3, 32'd3,  32'd1023},
        '{1'b1, 4'd2,  10'd2,    10'd1, 32'd32, 32'd64},
        '{1'b0, 4'd3,  10'd3,    10'd2, 32'd128, 32'd192},
        '{1'b1, 4'd15, 10'd2,    10'd1, 32'd64, 32'd128}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_rdata;
    logic              pwm_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwm_prescale_timer #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (10),
        .EXP_MAX (EXP_MAX)
    ) i_pwm_prescale_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input logic run, input logic hold,
                                              input logic dl, input logic [3:0] dh);
        return (32'(dh) << 16) | (32'(dl) << 15) | (32'(hold) << 11) | 32'(run);
    endfunction

    function automatic logic [31:0] cnt_word(input logic [9:0] per, input logic [9:0] hi);
        return (32'(per) << 16) | 32'(hi);
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // one full period starting at a rising edge of the output
    task automatic measure(output int hi_c, output int per_c);
        int n = 0;
        hi_c = 0; per_c = 0;
        while (pwm_o !== 1'b0 && n < LIMIT) begin @(negedge clk); n++; end
        while (pwm_o !== 1'b1 && n < LIMIT) begin @(negedge clk); n++; end
        while (pwm_o === 1'b1 && n < LIMIT) begin hi_c++; @(negedge clk); n++; end
        per_c = hi_c;
        while (pwm_o === 1'b0 && n < LIMIT) begin per_c++; @(negedge clk); n++; end
    endtask

    // length of the first high pulse from now
    task automatic first_high(output int hi_c);
        int n = 0;
        hi_c = 0;
        while (pwm_o !== 1'b1 && n < LIMIT) begin @(negedge clk); n++; end
        while (pwm_o === 1'b1 && n < LIMIT) begin hi_c++; @(negedge clk); n++; end
    endtask

    // counts samples where the output differs from lvl
    task automatic count_off(input logic lvl, input int len, output int bad);
        bad = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (pwm_o !== lvl) bad++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int h, p, bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, rv); check("R1 ctrl", rv, 32'h0);
        rd(4, rv); check("R1 count", rv, 32'h0);
        check("R1 pwm", 32'(pwm_o), 32'h0);

        // R4 R6 vector walk
        for (int v = 0; v < NVEC; v++) begin
            wr(0, 32'h0);
            wr(4, cnt_word(VECS[v].per, VECS[v].hi));
            wr(0, ctrl_word(1'b1, 1'b0, VECS[v].dl, VECS[v].dh));
            measure(h, p);
            check($sformatf("R4 R6 vec%0d high", v), 32'(h), VECS[v].exp_hi);
            check($sformatf("R4 R6 vec%0d period", v), 32'(p), VECS[v].exp_per);
        end

        // R5 high time at or above period
        wr(0, 32'h0);
        wr(4, cnt_word(10'd5, 10'd9));
        wr(0, ctrl_word(1'b1, 1'b0, 1'b0, 4'd0));
        repeat (3) @(negedge clk);
        count_off(1'b1, 40, bad); check("R5 hi>per", 32'(bad), 32'h0);
        wr(4, cnt_word(10'd5, 10'd5));
        repeat (8) @(negedge clk);
        count_off(1'b1, 40, bad); check("R5 hi=per", 32'(bad), 32'h0);

        // R2 readback, R3 unmapped
        wr(0, 32'h0);
        wr(4, 32'hFFFF_FFFF);
        wr(0, 32'hFFFF_FFFF);
        rd(0, rv); check("R2 ctrl", rv, 32'h000F_8811);
        rd(4, rv); check("R2 count", rv, 32'h03FF_03FF);
        wr(8, 32'hFFFF_FFFF);
        wr(12, 32'h1234_5678);
        rd(8, rv);  check("R3 read 0x8", rv, 32'h0);
        rd(12, rv); check("R3 read 0xC", rv, 32'h0);
        rd(0, rv);  check("R3 ctrl kept", rv, 32'h000F_8811);
        rd(4, rv);  check("R3 count kept", rv, 32'h03FF_03FF);
        wr(0, 32'h0);

        // R7 enable refused with zero fields
        wr(4, 32'h0);
        wr(0, ctrl_word(1'b1, 1'b0, 1'b0, 4'd0));
        rd(0, rv); check("R7 both zero", rv, 32'h0);
        wr(4, cnt_word(10'd4, 10'd0));
        wr(0, ctrl_word(1'b1, 1'b0, 1'b0, 4'd0));
        rd(0, rv); check("R7 high zero", rv, 32'h0);
        count_off(1'b0, 20, bad); check("R7 pwm low", 32'(bad), 32'h0);

        // R8 zero written while running
        wr(4, cnt_word(10'd4, 10'd2));
        wr(0, ctrl_word(1'b1, 1'b0, 1'b0, 4'd0));
        measure(h, p); check("R8 before", 32'(p), 32'd4);
        wr(4, cnt_word(10'd4, 10'd0));
        count_off(1'b0, 40, bad); check("R8 held low", 32'(bad), 32'h0);
        rd(0, rv); check("R8 enable kept", rv, 32'h1);
        wr(4, cnt_word(10'd4, 10'd2));
        first_high(h); check("R8 restart high", 32'(h), 32'd2);

        // R9 disable and re-enable
        wr(0, 32'h0);
        count_off(1'b0, 20, bad); check("R9 disabled low", 32'(bad), 32'h0);
        wr(4, cnt_word(10'd3, 10'd1));
        wr(0, ctrl_word(1'b1, 1'b0, 1'b0, 4'd1));
        first_high(h); check("R9 first pulse", 32'(h), 32'd4);
        repeat (5) @(negedge clk);
        wr(0, 32'h0);
        wr(0, ctrl_word(1'b1, 1'b0, 1'b0, 4'd1));
        first_high(h); check("R9 restart pulse", 32'(h), 32'd4);

        // R10 hold bit stages period, high time and divider
        wr(0, 32'h0);
        wr(4, cnt_word(10'd4, 10'd2));
        wr(0, ctrl_word(1'b1, 1'b1, 1'b0, 4'd0));
        wr(4, cnt_word(10'd8, 10'd6));
        wr(0, ctrl_word(1'b1, 1'b1, 1'b1, 4'd0));
        measure(h, p);
        check("R10 held high", 32'(h), 32'd2);
        check("R10 held period", 32'(p), 32'd4);
        wr(0, ctrl_word(1'b1, 1'b0, 1'b1, 4'd0));
        measure(h, p);
        check("R10 commit high", 32'(h), 32'd12);
        check("R10 commit period", 32'(p), 32'd16);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule